// File: doc/BRIEF.md
# Codec Serial Host Port with Control Slot

This block is the synchronous serial link between a host processor and a voice-band codec. Every frame the host raises a one-cycle frame sync. The port then runs a 16-cycle slot in which it shifts a parallel transmit word (the converter sample) out on a serial line, MSB first in two's complement. In the same slot it shifts the host's incoming word (the playback sample) in. The received word is presented on a parallel output with a one-cycle valid strobe.

A two-bit mode select and, in the software modes, the least significant bit of the incoming word decide whether a second slot follows in the same frame. In that second slot the host sends a control word and the port returns a register word. When the port is the timing master it raises the mid-frame sync for that slot itself. When it is a slave, the host must supply the pulse. If the host does not, the next sync it sends opens the control slot, and that frame's data sample is lost.

The whole block runs on the shift clock. Serial input is captured and serial output is launched on the same rising edge, so the host samples on the opposite edge.

Top module: `csp_host_port`

## Requirements
- R1: A slot begins on the edge that sees `frame_sync` (or the internal mid-frame sync) high while idle. `ser_oe` is then high for exactly W cycles. In the cycle after slot edge k (k = 0 … W-1), `ser_out` carries bit W-1-k of the word loaded at that first edge.
- R2: `ser_in` is captured MSB first on slot edges 1 … W. A data slot's word appears on `rx_data` with `rx_valid` high for the single cycle after edge W.
- R3: With `mode_sel` = 2'b00 and incoming bit 0 = 0 (software data-only), `rx_data` shows the word with bit 0 forced to 0, and no control slot or mid-frame sync follows.
- R4: With `mode_sel` = 2'b00 and incoming bit 0 = 1 (software mixed), a control slot is requested for the same frame, and `rx_data` shows bit 0 as 0.
- R5: With `mode_sel` = 2'b01 (hardware data-only), all W bits appear on `rx_data`, and bit 0 never requests a control slot.
- R6: With `mode_sel[1]` = 1 (hardware mixed, `mode_sel[0]` ignored), all W bits appear on `rx_data`, and a control slot is always requested.
- R7: In master mode (`master_en` = 1) with a control slot requested, `mid_sync` is a one-cycle pulse in the cycle after edge HALF-1, counted from the primary sync edge (HALF = FRAME_LEN/2). The control slot starts on edge HALF.
- R8: In a control slot, `reg_data` is shifted out in place of `tx_data`. The incoming word appears on `ctrl_data` with a one-cycle `ctrl_valid`, and `rx_valid` stays low.
- R9: In slave mode `mid_sync` stays low. With a control slot pending, the next `frame_sync` opens the control slot even when it is meant as the next frame's primary sync, so that data sample is lost. The frame after it is a normal data slot.
- R10: Outside a slot, `ser_oe` and `ser_out` are 0. A `frame_sync` pulse during a slot starts no new slot and produces no extra result.
- R11: After reset, `ser_out`, `ser_oe`, `mid_sync`, `rx_valid` and `ctrl_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1: port generates the mid-frame sync; 0: host supplies it |
| mode_sel | input | 2 | Transfer mode select (see R3–R6) |
| frame_sync | input | 1 | Frame sync pulse from the host |
| ser_in | input | 1 | Serial word from the host |
| tx_data | input | W | Data word to send, loaded at data slot start |
| reg_data | input | W | Register word to send, loaded at control slot start |
| ser_out | output | 1 | Serial word to the host |
| ser_oe | output | 1 | High while a slot drives `ser_out` |
| mid_sync | output | 1 | Generated mid-frame sync pulse (master mode) |
| rx_data | output | W | Received data word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| ctrl_data | output | W | Received control word |
| ctrl_valid | output | 1 | One-cycle strobe for `ctrl_data` |

## Verification
The bench builds the port with W = 16 and FRAME_LEN = 40. This puts the mid-frame pulse only three idle cycles after the end of the primary slot, so the pulse delay is measured exactly. It also lets master-mode frames run back to back with almost no slack. Slave runs use the same sizing to cover the host-driven second sync and the lost-sample case, in which the next primary sync is consumed as the control slot.

// File: rtl/csp_pkg.sv
package csp_pkg;

    typedef enum logic {
        SLOT_DATA = 1'b0,
        SLOT_CTRL = 1'b1
    } slot_kind_e;

    typedef struct packed {
        logic keep_lsb;   // full-width data word is useful
        logic want_ctrl;  // a control slot follows in this frame
    } frame_dec_t;

    // mode_sel: 2'b00 software, 2'b01 hardware data-only, 2'b1x hardware mixed
    function automatic frame_dec_t decode_frame(input logic [1:0] sel, input logic lsb);
        frame_dec_t d;
        d.keep_lsb  = (sel != 2'b00);
        d.want_ctrl = sel[1] | ((sel == 2'b00) & lsb);
        return d;
    endfunction

endpackage

// File: rtl/csp_shift_engine.sv
module csp_shift_engine #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] load_word,
    input  logic         ser_in,
    output logic         busy,
    output logic         last,
    output logic [W-1:0] rx_next,
    output logic         ser_out,
    output logic         ser_oe
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  tx_sr;
    logic [W-1:0]  rx_sr;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                bit_cnt <= '0;
                tx_sr   <= load_word;
            end
        end else begin
            rx_sr   <= rx_next;
            tx_sr   <= {tx_sr[W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
            if (last) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy    = busy_q;
    assign last    = busy_q && (bit_cnt == CW'(W - 1));
    assign rx_next = {rx_sr[W-2:0], ser_in};
    assign ser_oe  = busy_q;
    assign ser_out = busy_q & tx_sr[W-1];

endmodule

// File: rtl/csp_sync_ctl.sv
module csp_sync_ctl #(
    parameter int FRAME_LEN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic master_en,
    input  logic frame_sync,
    input  logic busy,
    input  logic prim_end,
    input  logic want_ctrl,
    output logic start,
    output logic start_sec,
    output logic mid_sync
);
    localparam int HALF = FRAME_LEN / 2;
    localparam int FW   = $clog2(FRAME_LEN + 1);

    logic [FW-1:0] frame_cnt;
    logic          pending;
    logic          mid_q;

    assign start     = ~busy & (frame_sync | mid_q);
    assign start_sec = start & (master_en ? mid_q : pending);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '1;
            pending   <= 1'b0;
            mid_q     <= 1'b0;
        end else begin
            if (start && !start_sec) begin
                frame_cnt <= '0;
            end else if (frame_cnt != '1) begin
                frame_cnt <= frame_cnt + 1'b1;
            end

            if (start_sec) begin
                pending <= 1'b0;
            end else if (prim_end && want_ctrl) begin
                pending <= 1'b1;
            end

            mid_q <= master_en & pending & (frame_cnt == FW'(HALF - 2));
        end
    end

    assign mid_sync = mid_q;

endmodule

// File: rtl/csp_host_port.sv
module csp_host_port
    import csp_pkg::*;
#(
    parameter int W         = 16,
    parameter int FRAME_LEN = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         master_en,
    input  logic [1:0]   mode_sel,
    input  logic         frame_sync,
    input  logic         ser_in,
    input  logic [W-1:0] tx_data,
    input  logic [W-1:0] reg_data,
    output logic         ser_out,
    output logic         ser_oe,
    output logic         mid_sync,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    output logic [W-1:0] ctrl_data,
    output logic         ctrl_valid
);
    logic         start;
    logic         start_sec;
    logic         busy;
    logic         last;
    logic [W-1:0] rx_next;
    logic [W-1:0] load_word;
    logic         prim_end;
    slot_kind_e   kind_q;
    frame_dec_t   dec;

    assign load_word = start_sec ? reg_data : tx_data;
    assign dec       = decode_frame(mode_sel, rx_next[0]);
    assign prim_end  = last && (kind_q == SLOT_DATA);

    csp_sync_ctl #(.FRAME_LEN(FRAME_LEN)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .master_en (master_en),
        .frame_sync(frame_sync),
        .busy      (busy),
        .prim_end  (prim_end),
        .want_ctrl (dec.want_ctrl),
        .start     (start),
        .start_sec (start_sec),
        .mid_sync  (mid_sync)
    );

    csp_shift_engine #(.W(W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load_word(load_word),
        .ser_in   (ser_in),
        .busy     (busy),
        .last     (last),
        .rx_next  (rx_next),
        .ser_out  (ser_out),
        .ser_oe   (ser_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q     <= SLOT_DATA;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            ctrl_data  <= '0;
            ctrl_valid <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            ctrl_valid <= 1'b0;
            if (start && !busy) begin
                kind_q <= start_sec ? SLOT_CTRL : SLOT_DATA;
            end
            if (last) begin
                if (kind_q == SLOT_DATA) begin
                    rx_data  <= dec.keep_lsb ? rx_next : {rx_next[W-1:1], 1'b0};
                    rx_valid <= 1'b1;
                end else begin
                    ctrl_data  <= rx_next;
                    ctrl_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/csp_host_port_chk.sv
module csp_host_port_chk (
    input logic clk,
    input logic rst,
    input logic master_en,
    input logic frame_sync,
    input logic ser_out,
    input logic ser_oe,
    input logic mid_sync,
    input logic rx_valid,
    input logic ctrl_valid
);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !ser_oe |-> !ser_out);

    p_slot_needs_sync_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_oe) |-> $past(frame_sync || mid_sync));

    p_rx_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_result_after_slot_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid || ctrl_valid) |-> $past(ser_oe));

    p_one_result_r8: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && ctrl_valid));

    p_ctrl_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl_valid |=> !ctrl_valid);

    p_mid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        mid_sync |=> !mid_sync);

    p_mid_master_only_r9: assert property (@(posedge clk) disable iff (rst)
        mid_sync |-> $past(master_en));
endmodule

bind csp_host_port csp_host_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .master_en (master_en),
    .frame_sync(frame_sync),
    .ser_out   (ser_out),
    .ser_oe    (ser_oe),
    .mid_sync  (mid_sync),
    .rx_valid  (rx_valid),
    .ctrl_valid(ctrl_valid)
);

// File: tb/tb_csp_host_port.sv
module tb_csp_host_port;
    localparam int W    = 16;
    localparam int FL   = 40;
    localparam int HALF = FL / 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         master_en = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic         frame_sync = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic [W-1:0] reg_data = '0;
    logic         ser_out, ser_oe, mid_sync, rx_valid, ctrl_valid;
    logic [W-1:0] rx_data, ctrl_data;

    always #5 clk = ~clk;

    csp_host_port #(.W(W), .FRAME_LEN(FL)) dut (
        .clk(clk), .rst(rst), .master_en(master_en), .mode_sel(mode_sel),
        .frame_sync(frame_sync), .ser_in(ser_in), .tx_data(tx_data),
        .reg_data(reg_data), .ser_out(ser_out), .ser_oe(ser_oe),
        .mid_sync(mid_sync), .rx_data(rx_data), .rx_valid(rx_valid),
        .ctrl_data(ctrl_data), .ctrl_valid(ctrl_valid)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit           is_ctrl;
        logic [W-1:0] word;
        string        req;
    } exp_t;
    exp_t expq[$];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (!rst && (rx_valid || ctrl_valid)) begin
            if (expq.size() == 0) begin
                check("R10", "unexpected result", {30'd0, rx_valid, ctrl_valid}, 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(e.req, "result kind", {31'd0, ctrl_valid}, {31'd0, e.is_ctrl});
                check(e.req, "result word", ctrl_valid ? ctrl_data : rx_data, e.word);
            end
        end
    end

    // drives one slot; via_mid: caller already sits on the negedge where mid_sync is high
    task automatic run_slot(input bit via_mid, input logic [W-1:0] din,
                            input logic [W-1:0] exp_out, input bit exp_ctrl,
                            input logic [W-1:0] exp_word, input string req,
                            input bit poke);
        logic [W-1:0] got = '0;
        int oe_bad = 0;
        exp_t e;
        if (!via_mid) begin
            @(negedge clk);
            frame_sync = 1'b1;
        end
        e.is_ctrl = exp_ctrl;
        e.word    = exp_word;
        e.req     = req;
        expq.push_back(e);
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            frame_sync = poke && (k == 8);
            ser_in     = din[W-1-k];
            if (ser_oe !== 1'b1) oe_bad++;
            got = {got[W-2:0], ser_out};
        end
        @(negedge clk);
        frame_sync = 1'b0;
        ser_in     = 1'b0;
        check("R1", {req, " serial out"}, got, exp_out);
        check("R1", "oe held for slot", oe_bad, 0);
        check("R10", "oe low after slot", ser_oe, 1'b0);
    endtask

    task automatic idle_watch(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mid_sync !== 1'b0 || ser_oe !== 1'b0 || ser_out !== 1'b0) hits++;
        end
        check(req, "no mid sync or slot while idle", hits, 0);
    endtask

    task automatic wait_mid(input string req);
        int n = 0;
        while (mid_sync !== 1'b1 && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(req, "mid sync delay after slot end", n, HALF - 17);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11", "reset outputs", {ser_out, ser_oe, mid_sync, rx_valid, ctrl_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R11", "outputs after reset", {ser_out, ser_oe, mid_sync, rx_valid, ctrl_valid}, 0);

        // slave, hardware data-only: lsb=1 requests nothing
        tx_data  = 16'h1234;
        reg_data = 16'hBEEF;
        mode_sel = 2'b01;
        run_slot(0, 16'hA5C3, 16'h1234, 0, 16'hA5C3, "R5", 0);
        idle_watch(HALF + 4, "R5");

        // slave, software data-only
        mode_sel = 2'b00;
        tx_data  = 16'h8001;
        run_slot(0, 16'h7FF0, 16'h8001, 0, 16'h7FF0, "R3", 0);
        idle_watch(HALF + 4, "R3");
        tx_data = 16'hFFFE;
        run_slot(0, 16'h8002, 16'hFFFE, 0, 16'h8002, "R2", 0);
        idle_watch(6, "R3");

        // slave, software mixed: host supplies second sync
        tx_data = 16'h0F00;
        run_slot(0, 16'h4321, 16'h0F00, 0, 16'h4320, "R4", 0);
        idle_watch(2, "R9");
        run_slot(0, 16'hC0DE, 16'hBEEF, 1, 16'hC0DE, "R8", 0);
        idle_watch(6, "R9");

        // slave, hardware mixed with no second sync: next frame consumed
        mode_sel = 2'b11;
        tx_data  = 16'h7777;
        run_slot(0, 16'h0001, 16'h7777, 0, 16'h0001, "R6", 0);
        idle_watch(FL - 18, "R9");
        mode_sel = 2'b01;
        run_slot(0, 16'h5555, 16'hBEEF, 1, 16'h5555, "R9", 0);
        idle_watch(4, "R9");
        run_slot(0, 16'h3C3C, 16'h7777, 0, 16'h3C3C, "R9", 0);
        idle_watch(4, "R9");

        // sync pulse during a slot is ignored
        tx_data = 16'h2468;
        run_slot(0, 16'h1357, 16'h2468, 0, 16'h1357, "R10", 1);
        idle_watch(HALF, "R10");

        // master, hardware mixed (aux bit ignored)
        master_en = 1'b1;
        mode_sel  = 2'b10;
        tx_data   = 16'h8000;
        reg_data  = 16'h9ABC;
        run_slot(0, 16'h8000, 16'h8000, 0, 16'h8000, "R6", 0);
        wait_mid("R7");
        run_slot(1, 16'h1F2E, 16'h9ABC, 1, 16'h1F2E, "R7", 0);
        idle_watch(4, "R7");

        // master, software mixed
        mode_sel = 2'b00;
        tx_data  = 16'h00FF;
        reg_data = 16'h6E6E;
        run_slot(0, 16'h0F0F, 16'h00FF, 0, 16'h0F0E, "R4", 0);
        wait_mid("R7");
        run_slot(1, 16'hE001, 16'h6E6E, 1, 16'hE001, "R8", 0);
        idle_watch(4, "R8");

        // master, hardware data-only: no mid sync
        mode_sel = 2'b01;
        run_slot(0, 16'hFFFF, 16'h00FF, 0, 16'hFFFF, "R5", 0);
        idle_watch(HALF + 4, "R7");

        check("R2", "all expected results seen", expq.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule